// File: doc/BRIEF.md
# NAND Page Copy-Back Sequencer

This block sits on the host side of a byte-wide NAND flash bus. It relocates one page to another page inside the flash array, and the page data never crosses the bus. A single start pulse supplies a source and a destination page address. The sequencer then drives the command-latch, address-latch, write, read and chip-enable strobes by itself. It loads the source page into the flash's internal buffer and waits for the array to come ready. It then issues the copy-back program with the destination address and confirms it. Finally it polls the status register until the operation completes.

The flash can only copy a page within one plane, so the sequencer checks the plane bit of both addresses when the request arrives. If the plane bits differ, it rejects the request in the same cycle and the bus stays idle. At the end of every request the sequencer gives a one-cycle done pulse. A pass/fail result, a plane error flag and a timeout flag remain readable until the next request is accepted.

Top module: `nand_cpyback_seq`

## Requirements
- R1: After reset the strobes are inactive (we_n_o, re_n_o and ce_n_o high; cle_o, ale_o and bus_oe_o low), and done_o, fail_o, err_plane_o and err_tmo_o are 0.
- R2: An accepted request first writes command byte 0x00 with cle_o=1 and ale_o=0. It then writes the three source address bytes, bits [7:0] first, then [15:8], then [23:16], each with ale_o=1 and cle_o=0. A byte is latched on the rising edge of we_n_o.
- R3: Between the source address and the copy-back command, no read strobe (re_n_o) is pulsed. The copy-back command is not written while the flash reports busy (rb_n_i low).
- R4: Once the flash is ready after the load, the sequencer writes command 0x8A, then the three destination address bytes in the same byte order as R2, then the confirm command 0x10.
- R5: If source and destination differ in bit PLANE_BIT (default 14), the request is refused. done_o and err_plane_o are 1 in the cycle after the start, and we_n_o never pulses.
- R6: After the program busy period ends, the sequencer writes command 0x70. It then pulses re_n_o and samples bus_i once per pulse, and keeps reading until status bit 6 is 1.
- R7: When status bit 6 is 1, fail_o takes the value of status bit 0 (1 means failure), and done_o is high for exactly one cycle.
- R8: If a busy wait or the status poll lasts TMO_CYC cycles, the request ends with err_tmo_o=1 and a done pulse. No further bus cycles follow. A request that times out during the load issues exactly four writes.
- R9: fail_o, err_plane_o and err_tmo_o hold their values while idle, and they are cleared when the next request is accepted.
- R10: cle_o and ale_o are never high together, and we_n_o and re_n_o are never low together.
- R11: A start pulse that arrives while a request is in progress is ignored: the addresses written on the bus remain those of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| src_addr_i | input | 24 | Source page address |
| dst_addr_i | input | 24 | Destination page address |
| rb_n_i | input | 1 | Flash ready/busy, low while busy (asynchronous) |
| bus_i | input | 8 | Flash data bus, read direction |
| bus_o | output | 8 | Flash data bus, write direction |
| bus_oe_o | output | 1 | Drive enable for bus_o |
| cle_o | output | 1 | Command-latch strobe |
| ale_o | output | 1 | Address-latch strobe |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| ce_n_o | output | 1 | Chip enable, active low |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Program failed (status bit 0) |
| err_plane_o | output | 1 | Request refused: planes differ |
| err_tmo_o | output | 1 | Ready or status never arrived in time |

## Verification
The bench builds the block with WAIT_MIN=4 and TMO_CYC=300. With a timeout that short, a flash model held busy forever exhausts the load wait within a few hundred cycles, so the timeout path can be exercised alongside normal moves. The bench varies busy lengths of 20 to 60 cycles, so that the ready/busy synchroniser and the minimum wait both come into play. Status polls that need one to three reads exercise the re-read loop. The address pairs put the plane bit at 0, at 1 and mismatched.

// File: rtl/nand_cb_pkg.sv
package nand_cb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RCMD,
    S_RADR,
    S_RWAIT,
    S_PCMD,
    S_PADR,
    S_PCONF,
    S_PWAIT,
    S_SCMD,
    S_SREAD,
    S_DONE
  } seq_st_e;

  localparam logic [7:0] OP_READ = 8'h00;
  localparam logic [7:0] OP_CPYB = 8'h8A;
  localparam logic [7:0] OP_CONF = 8'h10;
  localparam logic [7:0] OP_STAT = 8'h70;

  localparam int ST_RDY_BIT  = 6;
  localparam int ST_FAIL_BIT = 0;

endpackage

// File: rtl/nand_cb_rstsync.sv
module nand_cb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_o = sh_q[1];

endmodule

// File: rtl/nand_cb_sync.sv
module nand_cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/nand_cb_timer.sv
module nand_cb_timer #(
  parameter int WAIT_MIN = 4,
  parameter int TMO_CYC  = 65535
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic min_ok_o,
  output logic tmo_o
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] MIN_V = CW'(WAIT_MIN);
  localparam logic [CW-1:0] TMO_V = CW'(TMO_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (run_i && (cnt_q != TMO_V));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign min_ok_o = (cnt_q >= MIN_V);
  assign tmo_o    = (cnt_q == TMO_V);

endmodule

// File: rtl/nand_cb_ctrl.sv
module nand_cb_ctrl
  import nand_cb_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PLANE_BIT  = 14,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          rb_rdy_i,
  input  logic          min_ok_i,
  input  logic          tmo_i,
  input  logic [7:0]    stat_i,
  output logic          tclr_o,
  output logic          trun_o,
  output logic [7:0]    bus_o,
  output logic          bus_oe_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_n_o,
  output logic          re_n_o,
  output logic          ce_n_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          err_plane_o,
  output logic          err_tmo_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(ADDR_BYTES - 1);

  seq_st_e       st_q, st_d;
  logic          ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] src_q, dst_q;
  logic          addr_ld;
  logic [7:0]    stat_q;
  logic          stat_ld;
  logic          fail_q, fail_d;
  logic          perr_q, perr_d;
  logic          terr_q, terr_d;
  logic          wr_slot;

  // next-state
  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    fail_d  = fail_q;
    perr_d  = perr_q;
    terr_d  = terr_q;
    addr_ld = 1'b0;
    stat_ld = 1'b0;
    tclr_o  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          fail_d  = 1'b0;
          terr_d  = 1'b0;
          addr_ld = 1'b1;
          ph_d    = 1'b0;
          idx_d   = '0;
          if (src_i[PLANE_BIT] != dst_i[PLANE_BIT]) begin
            perr_d = 1'b1;
            st_d   = S_DONE;
          end else begin
            perr_d = 1'b0;
            st_d   = S_RCMD;
          end
        end
      end
      S_RCMD, S_PCMD: begin
        ph_d = ~ph_q;
        if (ph_q) begin
          idx_d = '0;
          st_d  = (st_q == S_RCMD) ? S_RADR : S_PADR;
        end
      end
      S_RADR, S_PADR: begin
        ph_d = ~ph_q;
        if (ph_q) begin
          if (idx_q == LAST_IDX) begin
            if (st_q == S_RADR) begin
              st_d   = S_RWAIT;
              tclr_o = 1'b1;
            end else begin
              st_d = S_PCONF;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_PCONF: begin
        ph_d = ~ph_q;
        if (ph_q) begin
          st_d   = S_PWAIT;
          tclr_o = 1'b1;
        end
      end
      S_RWAIT, S_PWAIT: begin
        if (tmo_i) begin
          terr_d = 1'b1;
          st_d   = S_DONE;
        end else if (min_ok_i && rb_rdy_i) begin
          ph_d = 1'b0;
          st_d = (st_q == S_RWAIT) ? S_PCMD : S_SCMD;
        end
      end
      S_SCMD: begin
        ph_d = ~ph_q;
        if (ph_q) st_d = S_SREAD;
      end
      S_SREAD: begin
        ph_d = ~ph_q;
        if (!ph_q) begin
          stat_ld = 1'b1;
        end else if (stat_q[ST_RDY_BIT]) begin
          fail_d = stat_q[ST_FAIL_BIT];
          st_d   = S_DONE;
        end else if (tmo_i) begin
          terr_d = 1'b1;
          st_d   = S_DONE;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= 1'b0;
      idx_q  <= '0;
      fail_q <= 1'b0;
      perr_q <= 1'b0;
      terr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      fail_q <= fail_d;
      perr_q <= perr_d;
      terr_q <= terr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (addr_ld) begin
      src_q <= src_i;
      dst_q <= dst_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ld) stat_q <= stat_i;
  end

  // outputs
  always_comb begin
    unique case (st_q)
      S_RCMD:  bus_o = OP_READ;
      S_RADR:  bus_o = src_q[8*idx_q +: 8];
      S_PCMD:  bus_o = OP_CPYB;
      S_PADR:  bus_o = dst_q[8*idx_q +: 8];
      S_PCONF: bus_o = OP_CONF;
      S_SCMD:  bus_o = OP_STAT;
      default: bus_o = 8'h00;
    endcase
  end

  assign wr_slot = (st_q == S_RCMD) || (st_q == S_RADR) || (st_q == S_PCMD) ||
                   (st_q == S_PADR) || (st_q == S_PCONF) || (st_q == S_SCMD);

  assign bus_oe_o    = wr_slot;
  assign cle_o       = (st_q == S_RCMD) || (st_q == S_PCMD) ||
                       (st_q == S_PCONF) || (st_q == S_SCMD);
  assign ale_o       = (st_q == S_RADR) || (st_q == S_PADR);
  assign we_n_o      = !(wr_slot && !ph_q);
  assign re_n_o      = !((st_q == S_SREAD) && !ph_q);
  assign ce_n_o      = (st_q == S_IDLE) || (st_q == S_DONE);
  assign done_o      = (st_q == S_DONE);
  assign trun_o      = (st_q == S_RWAIT) || (st_q == S_PWAIT) ||
                       (st_q == S_SCMD) || (st_q == S_SREAD);
  assign fail_o      = fail_q;
  assign err_plane_o = perr_q;
  assign err_tmo_o   = terr_q;

endmodule

// File: rtl/nand_cpyback_seq.sv
module nand_cpyback_seq #(
  parameter int ADDR_BYTES = 3,
  parameter int PLANE_BIT  = 14,
  parameter int WAIT_MIN   = 4,
  parameter int TMO_CYC    = 65535,
  localparam int AW = 8 * ADDR_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          rb_n_i,
  input  logic [7:0]    bus_i,
  output logic [7:0]    bus_o,
  output logic          bus_oe_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_n_o,
  output logic          re_n_o,
  output logic          ce_n_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          err_plane_o,
  output logic          err_tmo_o
);

  logic rst_n_s;
  logic rb_rdy;
  logic min_ok, tmo;
  logic tclr, trun;

  nand_cb_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  nand_cb_sync #(.STAGES(2)) u_rb (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (rb_n_i),
    .q_o   (rb_rdy)
  );

  nand_cb_timer #(.WAIT_MIN(WAIT_MIN), .TMO_CYC(TMO_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (tclr),
    .run_i    (trun),
    .min_ok_o (min_ok),
    .tmo_o    (tmo)
  );

  nand_cb_ctrl #(.ADDR_BYTES(ADDR_BYTES), .PLANE_BIT(PLANE_BIT)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .src_i       (src_addr_i),
    .dst_i       (dst_addr_i),
    .rb_rdy_i    (rb_rdy),
    .min_ok_i    (min_ok),
    .tmo_i       (tmo),
    .stat_i      (bus_i),
    .tclr_o      (tclr),
    .trun_o      (trun),
    .bus_o       (bus_o),
    .bus_oe_o    (bus_oe_o),
    .cle_o       (cle_o),
    .ale_o       (ale_o),
    .we_n_o      (we_n_o),
    .re_n_o      (re_n_o),
    .ce_n_o      (ce_n_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .err_plane_o (err_plane_o),
    .err_tmo_o   (err_tmo_o)
  );

endmodule

// File: rtl/nand_cb_chk.sv
module nand_cb_chk #(
  parameter int AW        = 24,
  parameter int PLANE_BIT = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] src_addr_i,
  input logic [AW-1:0] dst_addr_i,
  input logic          cle_o,
  input logic          ale_o,
  input logic          we_n_o,
  input logic          re_n_o,
  input logic          bus_oe_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          err_plane_o,
  input logic          err_tmo_o,
  input logic          idle
);

  // R10
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o) && !(bus_oe_o && !re_n_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  plane_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && (src_addr_i[PLANE_BIT] != dst_addr_i[PLANE_BIT]))
      |=> (done_o && err_plane_o && we_n_o && !cle_o && !ale_o));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_i) |=> ($stable(fail_o) && $stable(err_plane_o) && $stable(err_tmo_o)));

endmodule

bind nand_cpyback_seq nand_cb_chk #(.AW(AW), .PLANE_BIT(PLANE_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .src_addr_i  (src_addr_i),
  .dst_addr_i  (dst_addr_i),
  .cle_o       (cle_o),
  .ale_o       (ale_o),
  .we_n_o      (we_n_o),
  .re_n_o      (re_n_o),
  .bus_oe_o    (bus_oe_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .err_plane_o (err_plane_o),
  .err_tmo_o   (err_tmo_o),
  .idle        (ce_n_o && !done_o)
);

// File: tb/sim_nand_cpyback_seq.sv
`timescale 1ns/1ps
module sim_nand_cpyback_seq;

  localparam int TMO = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] src_addr_i = '0;
  logic [23:0] dst_addr_i = '0;
  logic        rb_n_i;
  logic [7:0]  bus_i;
  logic [7:0]  bus_o;
  logic        bus_oe_o, cle_o, ale_o, we_n_o, re_n_o, ce_n_o;
  logic        done_o, fail_o, err_plane_o, err_tmo_o;

  int checks = 0;
  int errors = 0;

  // flash model state
  int   cyc = 0;
  int   rb_until = 0;
  bit   busy_forever = 1'b0;
  int   busy_len = 20;
  int   poll_need = 0;
  bit   fail_cfg = 1'b0;
  int   rd_base = 0;
  int   nread = 0;
  int   logcnt = 0;
  logic [9:0] logv [0:255];
  logic [7:0] last_cmd = 8'hFF;
  int   acnt = 0;
  bit   rb_at_pcmd = 1'b0;
  int   rd_at_pcmd = 0;
  logic busy;
  logic st6;

  always #5 clk = ~clk;

  nand_cpyback_seq #(.WAIT_MIN(4), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .rb_n_i(rb_n_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o), .re_n_o(re_n_o),
    .ce_n_o(ce_n_o), .done_o(done_o), .fail_o(fail_o),
    .err_plane_o(err_plane_o), .err_tmo_o(err_tmo_o)
  );

  assign busy   = busy_forever || (cyc < rb_until);
  assign rb_n_i = ~busy;
  assign st6    = ((nread - rd_base) >= poll_need);
  assign bus_i  = {1'b0, st6, 5'b0, fail_cfg};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  always @(posedge we_n_o) begin
    logv[logcnt % 256] = {cle_o, ale_o, bus_o};
    logcnt = logcnt + 1;
    if (cle_o) begin
      last_cmd = bus_o;
      acnt = 0;
      if (bus_o == 8'h10) rb_until = cyc + 2 + busy_len;
      if (bus_o == 8'h8A) begin
        rb_at_pcmd = busy;
        rd_at_pcmd = nread;
      end
    end else if (ale_o) begin
      acnt = acnt + 1;
      if (last_cmd == 8'h00 && acnt == 3) rb_until = cyc + 2 + busy_len;
    end
  end

  always @(posedge re_n_o) nread = nread + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int ncyc);
    ncyc = 0;
    while (!done_o && ncyc < 5000) begin
      @(negedge clk);
      ncyc = ncyc + 1;
    end
  endtask

  task automatic check_entry(input int base, input int k, input bit c, input bit a,
                             input logic [7:0] b, input string req);
    logic [9:0] e;
    e = {c, a, b};
    chk(logv[(base + k) % 256] === e, req, $sformatf("write %0d", k),
        int'(logv[(base + k) % 256]), int'(e));
  endtask

  task automatic t_reset;
    chk(we_n_o === 1'b1 && re_n_o === 1'b1 && ce_n_o === 1'b1, "R1", "strobes high",
        {we_n_o, re_n_o, ce_n_o}, 3'b111);
    chk(cle_o === 1'b0 && ale_o === 1'b0 && bus_oe_o === 1'b0, "R1", "latches low",
        {cle_o, ale_o, bus_oe_o}, 0);
    chk({done_o, fail_o, err_plane_o, err_tmo_o} === 4'b0, "R1", "flags clear",
        {done_o, fail_o, err_plane_o, err_tmo_o}, 0);
  endtask

  task automatic t_move(input logic [23:0] s, input logic [23:0] d, input int blen,
                        input int pneed, input bit fbit, input bit stray);
    int base, nc, rb0;
    busy_len  = blen;
    poll_need = pneed;
    fail_cfg  = fbit;
    rd_base   = nread;
    rb0       = nread;
    base      = logcnt;
    @(negedge clk);
    src_addr_i = s; dst_addr_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(fail_o === 1'b0 && err_tmo_o === 1'b0 && err_plane_o === 1'b0, "R9",
        "flags cleared on accept", {fail_o, err_tmo_o, err_plane_o}, 0);
    if (stray) begin
      repeat (12) @(negedge clk);
      src_addr_i = 24'hA5A5A5 & ~24'h004000; dst_addr_i = 24'h5A5A5A & ~24'h004000;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(nc);
    chk(done_o === 1'b1, "R7", "done seen", done_o, 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R7", "done one cycle", done_o, 0);
    chk(logcnt - base == 10, "R6", "write count", logcnt - base, 10);
    check_entry(base, 0, 1'b1, 1'b0, 8'h00, "R2");
    for (int k = 0; k < 3; k++) check_entry(base, 1 + k, 1'b0, 1'b1, s[8*k +: 8], stray ? "R11" : "R2");
    check_entry(base, 4, 1'b1, 1'b0, 8'h8A, "R4");
    for (int k = 0; k < 3; k++) check_entry(base, 5 + k, 1'b0, 1'b1, d[8*k +: 8], stray ? "R11" : "R4");
    check_entry(base, 8, 1'b1, 1'b0, 8'h10, "R4");
    check_entry(base, 9, 1'b1, 1'b0, 8'h70, "R6");
    chk(rb_at_pcmd == 1'b0, "R3", "ready at copy-back cmd", rb_at_pcmd, 0);
    chk(rd_at_pcmd == rb0, "R3", "no read before copy-back", rd_at_pcmd - rb0, 0);
    chk(nread - rb0 == pneed + 1, "R6", "status reads", nread - rb0, pneed + 1);
    chk(fail_o === fbit, "R7", "fail bit", fail_o, fbit);
    chk(err_tmo_o === 1'b0 && err_plane_o === 1'b0, "R7", "no error", {err_tmo_o, err_plane_o}, 0);
    repeat (6) @(negedge clk);
    chk(fail_o === fbit, "R9", "fail held", fail_o, fbit);
  endtask

  task automatic t_plane;
    int base;
    base = logcnt;
    @(negedge clk);
    src_addr_i = 24'h001234; dst_addr_i = 24'h005678; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b1 && err_plane_o === 1'b1, "R5", "refused next cycle",
        {done_o, err_plane_o}, 2'b11);
    repeat (8) @(negedge clk);
    chk(logcnt - base == 0, "R5", "no bus writes", logcnt - base, 0);
    chk(err_plane_o === 1'b1, "R9", "plane error held", err_plane_o, 1);
  endtask

  task automatic t_timeout;
    int base, nc;
    base = logcnt;
    busy_forever = 1'b1;
    @(negedge clk);
    src_addr_i = 24'h0F0E0D; dst_addr_i = 24'h332211; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_plane_o === 1'b0, "R9", "plane error cleared", err_plane_o, 0);
    wait_done(nc);
    chk(done_o === 1'b1 && err_tmo_o === 1'b1, "R8", "timeout reported",
        {done_o, err_tmo_o}, 2'b11);
    chk(nc >= TMO, "R8", "timeout not early", nc, TMO);
    repeat (10) @(negedge clk);
    chk(logcnt - base == 4, "R8", "writes before timeout", logcnt - base, 4);
    chk(err_tmo_o === 1'b1, "R8", "timeout held", err_tmo_o, 1);
    busy_forever = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_move(24'h123456, 24'h0A1B2C, 20, 0, 1'b0, 1'b0);
    t_move(24'hFFC001, 24'h0140FE, 45, 2, 1'b1, 1'b0);
    t_plane();
    t_timeout();
    t_move(24'h00BEEF & ~24'h004000, 24'h7700AA, 60, 1, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule